// File: doc/BRIEF.md
# Key-Unlocked Configuration Port Controller

This block is a byte-wide configuration space reached through a pair of I/O ports: an index port at the low address and a data port at the next address up. The space is closed after reset. Software opens it by writing a fixed key byte to the index port twice in a row, and closes it again with a separate lock byte. While the space is open, a byte written to the index port picks a configuration register, and the data port reads or writes that register.

The space holds a logical-device select register, read-only identification bytes, and a bank of per-device registers. Each logical device has an enable bit and a 16-bit I/O base address; a base of zero means no address has been assigned. The select register chooses which bank the enable and base registers reach. The block drives the enable and base of every logical device out as plain vectors for the rest of the chip to decode. The hardware-monitor function is logical device 4. The block does no I/O decoding of the logical devices itself.

Top module: `cfg_port_ctrl`

## Requirements
- R1: After reset the space is locked, every device enable is 0 and every device base is 0x0000.
- R2: The space unlocks only when the index port (io_addr=0) receives the key byte 0x87 in two consecutive index-port writes. Any other index-port byte written while locked restarts the sequence, so 0x87, 0x55, 0x87 leaves the space locked.
- R3: While locked, reads of either port return 0xFF, and data-port writes change no register and no output.
- R4: Writing 0xAA to the index port while unlocked locks the space. Any other index-port byte, including 0x87, only loads the index.
- R5: Index 0x20 and 0x21 read 0x04 and 0x06, index 0x22 reads the revision parameter, and index 0x23 and 0x24 read 0x19 and 0x34. Data writes to these indices are ignored.
- R6: Index 0x07 is the logical-device select. It stores the full byte written and reads it back.
- R7: Index 0x30 bit 0 is the enable of the selected device and drives dev_enable[sel]. Bits 7:1 read as 0.
- R8: Index 0x60 holds the high byte and index 0x61 the low byte of the selected device's base. The base of device d drives dev_base[16*d+15 : 16*d], and both bytes read back.
- R9: Each device keeps its own enable and base. Writing through one select value leaves the other devices' enable and base unchanged.
- R10: When the select value is NUM_DEV or above, writes to 0x30, 0x60 and 0x61 are ignored and reads of them return 0x00.
- R11: Reads of any unimplemented index return 0x00. This includes index 0x87 loaded while unlocked, which leaves the space unlocked.
- R12: While unlocked, an index-port read returns the current index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 1 | Port select: 0 index port, 1 data port |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid while io_rd is high, 0x00 otherwise |
| dev_enable | output | NUM_DEV | Enable bit of each logical device |
| dev_base | output | 16*NUM_DEV | Base address of each logical device, device 0 in the low bits |

## Verification
The bench builds the block with NUM_DEV set to 5 and the revision byte set to 0x11. With these values the hardware-monitor device 4 is the highest implemented bank, so select values 5 and above test the out-of-range path of R10 with a short stimulus. A revision different from the default shows that the revision read comes from the parameter. Base values are written to devices 2 and 4 so that a write which leaks into another bank shows up on dev_base.

// File: rtl/cfg_port_pkg.sv
// Shared register indices and bank field codes for the configuration port.
// Assumes an 8-bit index space.
package cfg_port_pkg;
    localparam logic [7:0] IDX_LDSEL    = 8'h07;
    localparam logic [7:0] IDX_DEVID_HI = 8'h20;
    localparam logic [7:0] IDX_DEVID_LO = 8'h21;
    localparam logic [7:0] IDX_REV      = 8'h22;
    localparam logic [7:0] IDX_VEND_HI  = 8'h23;
    localparam logic [7:0] IDX_VEND_LO  = 8'h24;
    localparam logic [7:0] IDX_ENABLE   = 8'h30;
    localparam logic [7:0] IDX_BASE_HI  = 8'h60;
    localparam logic [7:0] IDX_BASE_LO  = 8'h61;

    typedef enum logic [1:0] {
        FLD_NONE    = 2'd0,
        FLD_ENABLE  = 2'd1,
        FLD_BASE_HI = 2'd2,
        FLD_BASE_LO = 2'd3
    } ldev_field_e;
endpackage

// File: rtl/cfg_unlock_seq.sv
// Tracks the lock state of the configuration space from index-port writes.
// Assumes a write strobe lasts one cycle per access. Two consecutive key
// bytes unlock the space, the lock byte closes it. While the space is
// unlocked, every other index byte is passed on as an index load.
module cfg_unlock_seq #(
    parameter logic [7:0] KEY_BYTE  = 8'h87,
    parameter logic [7:0] LOCK_BYTE = 8'hAA
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    output logic       unlocked,
    output logic       key_armed,
    output logic       idx_load
);
    // Lock state and half-complete key sequence
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unlocked  <= 1'b0;
            key_armed <= 1'b0;
        end else if (idx_wr) begin
            if (!unlocked) begin
                if (wdata == KEY_BYTE) begin
                    unlocked  <= key_armed;
                    key_armed <= !key_armed;
                end else begin
                    key_armed <= 1'b0;
                end
            end else if (wdata == LOCK_BYTE) begin
                unlocked <= 1'b0;
            end
        end
    end

    // An index write while unlocked that is not the lock byte loads the index
    assign idx_load = idx_wr && unlocked && (wdata != LOCK_BYTE);
endmodule

// File: rtl/cfg_ldev_bank.sv
// Holds the enable bit and 16-bit base address of each logical device.
// Assumes the caller gates wr_en with the unlock state. Select values of
// NUM_DEV and above reach no bank and read back as zero.
module cfg_ldev_bank
    import cfg_port_pkg::*;
#(
    parameter int NUM_DEV = 8,
    localparam int BASE_W = 16 * NUM_DEV
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  ldev_field_e       field,
    input  logic [7:0]        sel,
    input  logic [7:0]        wdata,
    output logic [NUM_DEV-1:0] dev_enable,
    output logic [BASE_W-1:0] dev_base,
    output logic              sel_enable,
    output logic [15:0]       sel_base
);
    for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
        localparam logic [7:0] DEV_IDX = 8'(g);
        logic hit;
        assign hit = wr_en && (sel == DEV_IDX);

        // Per-device register update on a write that targets this bank
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dev_enable[g]         <= 1'b0;
                dev_base[g*16 +: 16]  <= 16'h0000;
            end else if (hit) begin
                case (field)
                    FLD_ENABLE:  dev_enable[g]          <= wdata[0];
                    FLD_BASE_HI: dev_base[g*16+8 +: 8]  <= wdata;
                    FLD_BASE_LO: dev_base[g*16 +: 8]    <= wdata;
                    default: ;
                endcase
            end
        end
    end

    // Read-back of the selected bank, zero when the select is out of range
    always_comb begin
        sel_enable = 1'b0;
        sel_base   = 16'h0000;
        for (int d = 0; d < NUM_DEV; d++) begin
            if (sel == 8'(d)) begin
                sel_enable = dev_enable[d];
                sel_base   = dev_base[d*16 +: 16];
            end
        end
    end
endmodule

// File: rtl/cfg_port_ctrl.sv
// Index/data configuration port with key-based unlock. The index port is at
// io_addr=0 and the data port at io_addr=1. Assumes one-cycle strobes and
// never both strobes in the same cycle. Read data is combinational from the
// strobe and the current state.
module cfg_port_ctrl
    import cfg_port_pkg::*;
#(
    parameter int          NUM_DEV   = 8,
    parameter logic [15:0] DEV_ID    = 16'h0406,
    parameter logic [7:0]  DEV_REV   = 8'h01,
    parameter logic [15:0] VENDOR_ID = 16'h1934,
    parameter logic [7:0]  KEY_BYTE  = 8'h87,
    parameter logic [7:0]  LOCK_BYTE = 8'hAA,
    localparam int         BASE_W    = 16 * NUM_DEV
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               io_addr,
    input  logic               io_wr,
    input  logic               io_rd,
    input  logic [7:0]         io_wdata,
    output logic [7:0]         io_rdata,
    output logic [NUM_DEV-1:0] dev_enable,
    output logic [BASE_W-1:0]  dev_base
);
    logic        idx_wr, dat_wr;
    logic        unlocked, key_armed, idx_load;
    logic [7:0]  index_q, sel_q;
    ldev_field_e field;
    logic        bank_wr;
    logic        sel_enable;
    logic [15:0] sel_base;
    logic [7:0]  reg_val;

    assign idx_wr = io_wr && !io_addr;
    assign dat_wr = io_wr && io_addr && unlocked;

    cfg_unlock_seq #(.KEY_BYTE(KEY_BYTE), .LOCK_BYTE(LOCK_BYTE)) u_unlock (
        .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .wdata(io_wdata),
        .unlocked(unlocked), .key_armed(key_armed), .idx_load(idx_load)
    );

    // Index register, loaded by index-port writes while unlocked
    always_ff @(posedge clk) begin
        if (!rst_n)        index_q <= 8'h00;
        else if (idx_load) index_q <= io_wdata;
    end

    // Logical-device select register
    always_ff @(posedge clk) begin
        if (!rst_n)                               sel_q <= 8'h00;
        else if (dat_wr && index_q == IDX_LDSEL)  sel_q <= io_wdata;
    end

    // Map the index onto a banked field
    always_comb begin
        case (index_q)
            IDX_ENABLE:  field = FLD_ENABLE;
            IDX_BASE_HI: field = FLD_BASE_HI;
            IDX_BASE_LO: field = FLD_BASE_LO;
            default:     field = FLD_NONE;
        endcase
    end
    assign bank_wr = dat_wr && (field != FLD_NONE);

    cfg_ldev_bank #(.NUM_DEV(NUM_DEV)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(bank_wr), .field(field),
        .sel(sel_q), .wdata(io_wdata), .dev_enable(dev_enable),
        .dev_base(dev_base), .sel_enable(sel_enable), .sel_base(sel_base)
    );

    // Value of the register the index points at
    always_comb begin
        case (index_q)
            IDX_LDSEL:    reg_val = sel_q;
            IDX_DEVID_HI: reg_val = DEV_ID[15:8];
            IDX_DEVID_LO: reg_val = DEV_ID[7:0];
            IDX_REV:      reg_val = DEV_REV;
            IDX_VEND_HI:  reg_val = VENDOR_ID[15:8];
            IDX_VEND_LO:  reg_val = VENDOR_ID[7:0];
            IDX_ENABLE:   reg_val = {7'b0, sel_enable};
            IDX_BASE_HI:  reg_val = sel_base[15:8];
            IDX_BASE_LO:  reg_val = sel_base[7:0];
            default:      reg_val = 8'h00;
        endcase
    end

    // Read data by port and lock state
    always_comb begin
        if (!io_rd)        io_rdata = 8'h00;
        else if (!unlocked) io_rdata = 8'hFF;
        else if (!io_addr)  io_rdata = index_q;
        else                io_rdata = reg_val;
    end
endmodule

// File: rtl/cfg_port_checker.sv
// Assertions on the configuration port, bound to every cfg_port_ctrl.
module cfg_port_checker #(
    parameter int         NUM_DEV   = 8,
    parameter logic [7:0] KEY_BYTE  = 8'h87,
    parameter logic [7:0] LOCK_BYTE = 8'hAA
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  io_addr,
    input logic                  io_wr,
    input logic                  io_rd,
    input logic [7:0]            io_wdata,
    input logic [7:0]            io_rdata,
    input logic [NUM_DEV-1:0]    dev_enable,
    input logic [16*NUM_DEV-1:0] dev_base,
    input logic                  unlocked,
    input logic                  key_armed
);
    AST_LOCKED_READ_FF: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlocked && io_rd) |-> io_rdata == 8'hFF); // R3
    AST_KEY_PAIR_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlocked && key_armed && io_wr && !io_addr && io_wdata == KEY_BYTE) |=> unlocked); // R2
    AST_FOREIGN_BYTE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlocked && io_wr && !io_addr && io_wdata != KEY_BYTE) |=> (!unlocked && !key_armed)); // R2
    AST_LOCK_BYTE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && io_wr && !io_addr && io_wdata == LOCK_BYTE) |=> !unlocked); // R4
    AST_LOCKED_OUTPUTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |=> ($stable(dev_enable) && $stable(dev_base))); // R3
    AST_ENABLE_NEEDS_DATA_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && io_addr) |=> $stable(dev_enable)); // R7
    AST_SINGLE_BANK_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $countones(dev_enable ^ $past(dev_enable)) <= 1); // R9
endmodule

bind cfg_port_ctrl cfg_port_checker #(
    .NUM_DEV(NUM_DEV), .KEY_BYTE(KEY_BYTE), .LOCK_BYTE(LOCK_BYTE)
) u_checker (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .dev_enable(dev_enable),
    .dev_base(dev_base), .unlocked(unlocked), .key_armed(key_armed)
);

// File: tb/test_cfg_port_ctrl.sv
// Scoreboard bench: read tasks queue expected bytes, a negedge monitor
// pops and compares them against io_rdata.
module test_cfg_port_ctrl;
    localparam int ND = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          io_addr = 1'b0, io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0]    io_wdata = 8'h00;
    logic [7:0]    io_rdata;
    logic [ND-1:0] dev_enable;
    logic [16*ND-1:0] dev_base;

    int total = 0;
    int bad   = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    cfg_port_ctrl #(.NUM_DEV(ND), .DEV_REV(8'h11)) i_cfg_port_ctrl (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
        .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .dev_enable(dev_enable), .dev_base(dev_base)
    );

    task automatic check(input logic [79:0] act, input logic [79:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compare each read strobe against the head of the queue
    always @(negedge clk) begin
        if (io_rd) begin
            if (exp_q.size() == 0) check(80'(io_rdata), 80'hXX, "unexpected read");
            else check(80'(io_rdata), 80'(exp_q.pop_front()), tag_q.pop_front());
        end
    end

    task automatic do_wr(input logic a, input logic [7:0] d);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(posedge clk); #1;
        io_wr = 1'b0;
    endtask

    task automatic do_rd(input logic a, input logic [7:0] exp, input string tag);
        io_addr = a; io_rd = 1'b1;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(posedge clk); #1;
        io_rd = 1'b0;
    endtask

    task automatic reg_wr(input logic [7:0] idx, input logic [7:0] v);
        do_wr(1'b0, idx); do_wr(1'b1, v);
    endtask

    task automatic reg_rd(input logic [7:0] idx, input logic [7:0] exp, input string tag);
        do_wr(1'b0, idx); do_rd(1'b1, exp, tag);
    endtask

    task automatic summary;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        check(80'd0, 80'd1, "watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        check(80'(dev_enable), 80'h0, "R1 enables after reset");
        check(dev_base, 80'h0, "R1 bases after reset");
        do_rd(1'b1, 8'hFF, "R1 locked after reset");

        // R2: broken key sequence stays locked
        do_wr(1'b0, 8'h87); do_wr(1'b0, 8'h55); do_wr(1'b0, 8'h87);
        do_rd(1'b1, 8'hFF, "R2 foreign byte restarts key");
        do_rd(1'b0, 8'hFF, "R3 index read while locked");
        do_wr(1'b0, 8'h87);
        do_rd(1'b0, 8'h00, "R2 second key unlocks, R12 index reads 0");

        // R5 identification
        reg_rd(8'h20, 8'h04, "R5 id high");
        reg_rd(8'h21, 8'h06, "R5 id low");
        reg_rd(8'h22, 8'h11, "R5 revision");
        reg_rd(8'h23, 8'h19, "R5 vendor high");
        reg_rd(8'h24, 8'h34, "R5 vendor low");
        reg_wr(8'h20, 8'hAB);
        do_rd(1'b1, 8'h04, "R5 id write ignored");

        // R6, R7, R8 on device 4
        reg_wr(8'h07, 8'h04);
        do_rd(1'b1, 8'h04, "R6 select readback");
        reg_wr(8'h30, 8'hFF);
        do_rd(1'b1, 8'h01, "R7 enable reads bit0 only");
        check(80'(dev_enable), 80'h10, "R7 dev_enable[4]");
        reg_wr(8'h60, 8'h12);
        reg_wr(8'h61, 8'h90);
        check(dev_base, 80'h1290 << 64, "R8 base of device 4");
        reg_rd(8'h60, 8'h12, "R8 base high readback");
        reg_rd(8'h61, 8'h90, "R8 base low readback");

        // R9 independent banks
        reg_wr(8'h07, 8'h02);
        reg_rd(8'h30, 8'h00, "R9 device 2 starts disabled");
        reg_wr(8'h30, 8'h01);
        reg_wr(8'h60, 8'h0A);
        reg_wr(8'h61, 8'h00);
        check(80'(dev_enable), 80'h14, "R9 both enables");
        check(dev_base, (80'h1290 << 64) | (80'h0A00 << 32), "R9 bases kept apart");
        reg_wr(8'h07, 8'h04);
        reg_rd(8'h61, 8'h90, "R9 device 4 base intact");

        // R10 out-of-range select
        reg_wr(8'h07, 8'h06);
        reg_wr(8'h30, 8'h01);
        reg_wr(8'h60, 8'hFF);
        check(80'(dev_enable), 80'h14, "R10 enables unchanged");
        check(dev_base, (80'h1290 << 64) | (80'h0A00 << 32), "R10 bases unchanged");
        reg_rd(8'h30, 8'h00, "R10 enable reads 0");
        reg_rd(8'h60, 8'h00, "R10 base reads 0");
        reg_rd(8'h07, 8'h06, "R6 full select byte");

        // R11 unimplemented indices, key byte as index
        reg_rd(8'h45, 8'h00, "R11 unimplemented 0x45");
        reg_rd(8'h87, 8'h00, "R11 key byte loads index");
        do_rd(1'b0, 8'h87, "R12 index readback 0x87");

        // R4 lock, R3 locked write ignored
        reg_wr(8'h07, 8'h02);
        do_wr(1'b0, 8'h30);
        do_wr(1'b0, 8'hAA);
        do_rd(1'b1, 8'hFF, "R4 lock byte closes");
        do_wr(1'b1, 8'h00);
        check(80'(dev_enable), 80'h14, "R3 locked write ignored");

        // Reopen and confirm state held
        do_wr(1'b0, 8'h87); do_wr(1'b0, 8'h87);
        do_rd(1'b0, 8'h30, "R4 index kept across lock");
        do_rd(1'b1, 8'h01, "R3 device 2 still enabled");
        summary();
    end
endmodule